// File: doc/BRIEF.md
# Dual-Lane Edge-Placed PWM Generator

This block drives two PWM lines. A shared prescaler divides the system clock by a power of two times a linear divisor. It emits one tick per divided period. A shared position counter advances on each tick and runs from 0 up to a programmable period unit, so one PWM period lasts (unit + 1) ticks. Each lane has its own rise point and fall point, taken from one 32-bit duty word. A lane's output goes high when the position reaches its rise point and low when the position reaches its fall point. This sets both the phase and the width of the pulse.

The period unit, rise points and fall points pass through shadow registers. These registers load only at the wrap of the position counter, so a change never cuts a period short. The two divisor fields act on the prescaler at once. Each lane is a three-state machine:
- `LANE_OFF`: the lane is disabled and its output is low.
- `LANE_LOW`: the lane is enabled and its output is low.
- `LANE_HIGH`: the lane is enabled and its output is high.

The transitions are:
- "disable": from any state to `LANE_OFF` when the lane enable is low.
- "arm": from `LANE_OFF` to `LANE_LOW`.
- "arm-rise": from `LANE_OFF` to `LANE_HIGH` when a tick lands on the rise point.
- "rise": from `LANE_LOW` to `LANE_HIGH` on a tick landing on the rise point.
- "fall": from `LANE_HIGH` to `LANE_LOW` on a tick landing on the fall point but not on the rise point.

Top module: `pwmrf_top`

## Requirements
- R1: The prescaler divisor is D = 2^div_hi × (div_lo == 0 ? 1 : 2·div_lo). A tick occurs every D clocks, and one PWM period lasts D × (unit + 1) clocks. A lane whose high time is neither 0 nor a full period shows exactly one rising edge per period.
- R2: Lane 0 takes its rise point from duty_word[7:0] and its fall point from duty_word[15:8]. Lane 1 takes its rise point from duty_word[23:16] and its fall point from duty_word[31:24].
- R3: At each tick the lane compares the new position p to its points. p == rise sets the output high, and this check has priority. Otherwise p == fall sets the output low. Between ticks the output does not change while the lane stays enabled. For rise < fall ≤ unit the output is high for fall − rise ticks per period. For fall < rise ≤ unit it is high for unit + 1 − rise + fall ticks.
- R4: When rise equals fall (including both 0), the output is high for the whole period (100 % duty).
- R5: A fall point of 0 with a nonzero rise point ≤ unit drops the output at the period end. The output is then high for unit + 1 − rise ticks.
- R6: A rise point above the period unit, with a fall point ≤ unit, gives a constantly low output.
- R7: When a lane's enable is low, its output is low from the next clock on. The other lane is not affected.
- R8: New period unit, rise and fall values take effect only at the wrap from position = unit to position 0. Until then the running period keeps the previous values.
- R9: The reset is synchronous and active high. It clears the prescaler, the position counter and the shadow registers, and holds both outputs low. The first tick after reset loads the current settings and starts a period at position 0.
- R10: The position counter changes only on a prescaler tick and never exceeds the latched period unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 2 | Per-lane enable, bit i for lane i |
| div_hi | input | 4 | Power-of-two divisor exponent |
| div_lo | input | 4 | Linear divisor field (0 means 1, N means 2N) |
| period_unit | input | 8 | Last position of a period; period is unit+1 ticks |
| duty_word | input | 32 | Packed rise/fall points of both lanes |
| pwm_o | output | 2 | PWM outputs, bit i for lane i |

## Verification
The bench aims at these corner cases:
- A rise point equal to the fall point, and a fall point of 0. A design that treated the fall check as dominant, or decoded a fall point of 0 literally, would produce 0 % duty or a pulse one tick off.
- A pulse that wraps across the period end, and a rise point beyond the unit. Both expose a design that does not carry the lane state across the wrap.
- A duty change made in the middle of a period, placed at a known phase after reset. A design without shadow registers would switch the output before the wrap.
- Random divisor, unit and point settings, measured as high-time and edge counts over one full period. These catch a wrong divisor encoding, an off-by-one in the period length, or swapped duty-word fields.

// File: rtl/pwmrf_pkg.sv
package pwmrf_pkg;

    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2
    } lane_state_e;

endpackage

// File: rtl/pwmrf_prescaler.sv
module pwmrf_prescaler #(
    parameter int HDIV_W = 4,
    parameter int LDIV_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HDIV_W-1:0] div_hi,
    input  logic [LDIV_W-1:0] div_lo,
    output logic              tick
);
    localparam int CNT_W = (1 << HDIV_W) - 1 + LDIV_W + 1;

    logic [CNT_W-1:0] lin_div;
    logic [CNT_W-1:0] full_div;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] pre_cnt;

    // linear stage: field 0 divides by one, field N by 2N
    always_comb begin
        if (div_lo == '0) begin
            lin_div = CNT_W'(1);
        end else begin
            lin_div = CNT_W'(div_lo) << 1;
        end
        full_div = lin_div << div_hi;
        last_cnt = full_div - CNT_W'(1);
    end

    assign tick = (pre_cnt >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwmrf_frame.sv
module pwmrf_frame #(
    parameter int LANES = 2,
    parameter int PT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [PT_W-1:0]            unit_in,
    input  logic [LANES-1:0][PT_W-1:0] rise_in,
    input  logic [LANES-1:0][PT_W-1:0] fall_in,
    output logic [PT_W-1:0]            pos,
    output logic [PT_W-1:0]            unit_sh,
    output logic [PT_W-1:0]            next_pos,
    output logic [LANES-1:0][PT_W-1:0] rise_eff,
    output logic [LANES-1:0][PT_W-1:0] fall_eff
);
    logic                       wrap;
    logic [LANES-1:0][PT_W-1:0] rise_sh;
    logic [LANES-1:0][PT_W-1:0] fall_sh;

    assign wrap     = step && (pos == unit_sh);
    assign next_pos = wrap ? '0 : pos + PT_W'(1);

    // at the wrap the freshly loaded points already govern position 0
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rise_eff[i] = wrap ? rise_in[i] : rise_sh[i];
            fall_eff[i] = wrap ? fall_in[i] : fall_sh[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            unit_sh <= '0;
            rise_sh <= '0;
            fall_sh <= '0;
        end else if (step) begin
            pos <= next_pos;
            if (wrap) begin
                unit_sh <= unit_in;
                rise_sh <= rise_in;
                fall_sh <= fall_in;
            end
        end
    end

endmodule

// File: rtl/pwmrf_lane.sv
module pwmrf_lane
    import pwmrf_pkg::*;
#(
    parameter int PT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            step,
    input  logic [PT_W-1:0] next_pos,
    input  logic [PT_W-1:0] rise,
    input  logic [PT_W-1:0] fall,
    output logic            pwm
);
    lane_state_e state_q;
    lane_state_e state_d;
    logic        hit_rise;
    logic        hit_fall;

    assign hit_rise = step && (next_pos == rise);
    assign hit_fall = step && (next_pos == fall);

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = LANE_OFF;
        end else begin
            unique case (state_q)
                LANE_OFF:  state_d = hit_rise ? LANE_HIGH : LANE_LOW;
                LANE_LOW:  if (hit_rise) state_d = LANE_HIGH;
                LANE_HIGH: if (hit_fall && !hit_rise) state_d = LANE_LOW;
                default:   state_d = LANE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LANE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwm = (state_q == LANE_HIGH);
    end

endmodule

// File: rtl/pwmrf_top.sv
module pwmrf_top #(
    parameter int LANES  = 2,
    parameter int PT_W   = 8,
    parameter int HDIV_W = 4,
    parameter int LDIV_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        lane_en,
    input  logic [HDIV_W-1:0]       div_hi,
    input  logic [LDIV_W-1:0]       div_lo,
    input  logic [PT_W-1:0]         period_unit,
    input  logic [2*LANES*PT_W-1:0] duty_word,
    output logic [LANES-1:0]        pwm_o
);
    localparam int LANE_BITS = 2 * PT_W;

    logic                       step;
    logic [PT_W-1:0]            frame_pos;
    logic [PT_W-1:0]            frame_unit;
    logic [PT_W-1:0]            next_pos;
    logic [LANES-1:0][PT_W-1:0] rise_in;
    logic [LANES-1:0][PT_W-1:0] fall_in;
    logic [LANES-1:0][PT_W-1:0] rise_eff;
    logic [LANES-1:0][PT_W-1:0] fall_eff;

    pwmrf_prescaler #(
        .HDIV_W (HDIV_W),
        .LDIV_W (LDIV_W)
    ) u_prescaler (
        .clk    (clk),
        .rst    (rst),
        .div_hi (div_hi),
        .div_lo (div_lo),
        .tick   (step)
    );

    pwmrf_frame #(
        .LANES (LANES),
        .PT_W  (PT_W)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .unit_in  (period_unit),
        .rise_in  (rise_in),
        .fall_in  (fall_in),
        .pos      (frame_pos),
        .unit_sh  (frame_unit),
        .next_pos (next_pos),
        .rise_eff (rise_eff),
        .fall_eff (fall_eff)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // each lane owns a rise byte followed by a fall byte
        assign rise_in[g] = duty_word[g*LANE_BITS +: PT_W];
        assign fall_in[g] = duty_word[g*LANE_BITS + PT_W +: PT_W];

        pwmrf_lane #(
            .PT_W (PT_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (lane_en[g]),
            .step     (step),
            .next_pos (next_pos),
            .rise     (rise_eff[g]),
            .fall     (fall_eff[g]),
            .pwm      (pwm_o[g])
        );
    end

endmodule

// File: rtl/pwmrf_checker.sv
module pwmrf_checker #(
    parameter int LANES = 2,
    parameter int PT_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] lane_en,
    input logic             step,
    input logic [PT_W-1:0]  pos,
    input logic [PT_W-1:0]  unit_sh,
    input logic [LANES-1:0] pwm
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            a_reset_low_r9: assert (pwm == '0)
                else $error("outputs not low after reset cycle");
        end
    end

    p_pos_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));

    p_pos_bound_r10: assert property (@(posedge clk) disable iff (rst)
        pos <= unit_sh);

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(step && pos == unit_sh) |=> $stable(unit_sh));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
            !lane_en[i] |=> !pwm[i]);

        p_edge_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
            (lane_en[i] && $past(lane_en[i]) && !step) |=> $stable(pwm[i]));
    end

endmodule

bind pwmrf_top pwmrf_checker #(
    .LANES (LANES),
    .PT_W  (PT_W)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .lane_en (lane_en),
    .step    (step),
    .pos     (frame_pos),
    .unit_sh (frame_unit),
    .pwm     (pwm_o)
);

// File: tb/pwmrf_top_bench.sv
module pwmrf_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  lane_en;
    logic [3:0]  div_hi;
    logic [3:0]  div_lo;
    logic [7:0]  period_unit;
    logic [31:0] duty_word;
    logic [1:0]  pwm_o;

    int errors = 0;
    int checks = 0;
    int cur_len = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwmrf_top u_pwmrf_top (
        .clk         (clk),
        .rst         (rst),
        .lane_en     (lane_en),
        .div_hi      (div_hi),
        .div_lo      (div_lo),
        .period_unit (period_unit),
        .duty_word   (duty_word),
        .pwm_o       (pwm_o)
    );

    function automatic int divisor(input int h, input int l);
        return (l == 0 ? 1 : 2 * l) << h;
    endfunction

    // expected high ticks per period for points within or beyond the unit
    function automatic int high_ticks(input int r, input int f, input int u);
        if (r > u) return 0;
        if (r == f) return u + 1;
        if (r < f) return f - r;
        return u + 1 - r + f;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int n, output int h0, output int h1,
                           output int e0, output int e1);
        logic [1:0] prev;
        h0 = 0; h1 = 0; e0 = 0; e1 = 0;
        @(negedge clk);
        prev = pwm_o;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            h0 += int'(pwm_o[0]);
            h1 += int'(pwm_o[1]);
            if (pwm_o[0] && !prev[0]) e0++;
            if (pwm_o[1] && !prev[1]) e1++;
            prev = pwm_o;
        end
    endtask

    task automatic run_case(input string req, input int h, input int l, input int u,
                            input int r0, input int f0, input int r1, input int f1);
        int d, len, x0, x1, h0, h1, e0, e1;
        d   = divisor(h, l);
        len = d * (u + 1);
        @(negedge clk);
        div_hi      = 4'(h);
        div_lo      = 4'(l);
        period_unit = 8'(u);
        duty_word   = {8'(f1), 8'(r1), 8'(f0), 8'(r0)};
        repeat (cur_len + 2 * len + 4) @(negedge clk);
        cur_len = len;
        measure(len, h0, h1, e0, e1);
        x0 = high_ticks(r0, f0, u);
        x1 = high_ticks(r1, f1, u);
        check({req, " lane0 high clocks"}, h0, x0 * d);
        check({req, " lane1 high clocks"}, h1, x1 * d);
        check({req, " R1 lane0 edges"}, e0, (x0 > 0 && x0 < u + 1) ? 1 : 0);
        check({req, " R1 lane1 edges"}, e1, (x1 > 0 && x1 < u + 1) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int h0, h1, e0, e1, seed_dummy;
        seed_dummy = $urandom(32'h0000_5eed);
        rst = 1'b1;
        lane_en = 2'b11;
        div_hi = 4'd0;
        div_lo = 4'd0;
        period_unit = 8'd15;
        // both lanes start at 0 %: rise 20 beyond unit 15, fall 0
        duty_word = {8'd0, 8'd20, 8'd0, 8'd20};
        repeat (3) @(negedge clk);
        check("R9 outputs during reset", int'(pwm_o), 0);

        // R8: known phase after reset, change duty mid-period
        rst = 1'b0;
        @(posedge clk);              // first tick loads settings, position 0
        repeat (5) @(posedge clk);
        @(negedge clk);
        duty_word = {8'd0, 8'd20, 8'd0, 8'd0}; // lane 0 to full duty
        repeat (10) @(posedge clk);  // last clock of the running period
        @(negedge clk);
        check("R8 lane0 before wrap", int'(pwm_o[0]), 0);
        @(posedge clk);
        @(negedge clk);
        check("R8 lane0 after wrap", int'(pwm_o[0]), 1);
        check("R8 lane1 unchanged", int'(pwm_o[1]), 0);
        cur_len = 16;

        // directed corners
        run_case("R4 equal points zero", 0, 0, 9, 0, 0, 5, 5);
        run_case("R5 fall at zero", 0, 1, 9, 4, 0, 9, 0);
        run_case("R6 rise beyond unit", 1, 0, 9, 12, 3, 10, 0);
        run_case("R3 wrapping pulse", 0, 0, 9, 7, 2, 2, 7);
        run_case("R1 large divisor", 2, 3, 3, 1, 3, 0, 2);
        run_case("R2 distinct lanes", 0, 2, 7, 1, 2, 3, 7);

        // R7: disable lane 0 while lane 1 runs at full duty
        run_case("R7 setup", 0, 0, 7, 0, 0, 3, 3);
        @(negedge clk);
        lane_en = 2'b10;
        @(posedge clk);
        @(negedge clk);
        check("R7 lane0 low next clock", int'(pwm_o[0]), 0);
        check("R7 lane1 still high", int'(pwm_o[1]), 1);
        measure(32, h0, h1, e0, e1);
        check("R7 lane0 high clocks while off", h0, 0);
        check("R7 lane1 high clocks", h1, 32);
        @(negedge clk);
        lane_en = 2'b11;
        repeat (20) @(negedge clk);
        measure(8, h0, h1, e0, e1);
        check("R7 lane0 restored", h0, 8);

        // random settings
        for (int it = 0; it < 20; it++) begin
            int h, l, u, r0, f0, r1, f1;
            h  = int'($urandom_range(2, 0));
            l  = int'($urandom_range(3, 0));
            u  = int'($urandom_range(15, 0));
            r0 = int'($urandom_range(u, 0));
            f0 = int'($urandom_range(u, 0));
            r1 = int'($urandom_range(u, 0));
            f1 = int'($urandom_range(u, 0));
            run_case("R3 R2 random", h, l, u, r0, f0, r1, f1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule